// File: doc/BRIEF.md
# Bus and Internal Error Reporter

This block collects error event pulses for one processing agent and turns them into three active-low error lines: one for errors that force a bus re-initialisation, one for recoverable bus errors, and one for internal errors. Recoverable bus errors are those that leave the bus protocol intact, for example a memory data error or a snoop error on a line that was not modified. Internal errors have nothing to do with bus operation, for example a parity error in either cache level. Each error line goes low for one clock in the cycle after an event of its class, however many sources of that class fire together.

The recoverable-bus-error driver is enabled or disabled by a strap. The strap is sampled while power-on reset is held and keeps its value until the next power-on reset, so a warm reset does not change it. Software writes one escalation bit per error class. When a class output asserts and its bit is set, the block pulses a machine-check request in the same cycle. Both resets clear every escalation bit.

Top module: `err_reporter`

## Requirements
- R1: The bus-error driver enable is taken from `strap_drv_en` while `por_n` is low and is held unchanged after that. Warm reset (`rst_n`) does not change it.
- R2: While the latched driver enable is 0, `bus_err_n` stays high and bus events never cause `mc_req`.
- R3: If any bit of `ev_bus` is high in a cycle and the driver is enabled, `bus_err_n` is low for exactly the next cycle. This is a single pulse even when several bits are high.
- R4: If any bit of `ev_int` is high in a cycle, `int_err_n` is low for exactly the next cycle, whatever the strap value.
- R5: If any bit of `ev_reinit` is high in a cycle, `reinit_err_n` is low for exactly the next cycle.
- R6: An error output is high in every cycle that follows a cycle with no enabled event of its class.
- R7: A cycle with `cfg_we` high loads `cfg_wdata` into the escalation bits at the clock edge. Bit 0 enables the bus re-init class, bit 1 the recoverable bus class and bit 2 the internal class. The new value applies to events from the following cycle on.
- R8: `mc_req` is high in exactly the cycles in which some class output is low and that class's escalation bit was set in the cycle of the event.
- R9: While `por_n` or `rst_n` is low, all error outputs are high, `mc_req` is low and the escalation bits are cleared.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; the strap is sampled while it is low |
| rst_n | input | 1 | Warm reset, active low |
| strap_drv_en | input | 1 | Strap that enables the bus-error driver |
| cfg_we | input | 1 | Write enable for the escalation bits |
| cfg_wdata | input | 3 | Escalation bits: [0] re-init, [1] bus, [2] internal |
| ev_reinit | input | N_REINIT | Bus re-init error event pulses |
| ev_bus | input | N_BUS | Recoverable bus error event pulses |
| ev_int | input | N_INT | Internal error event pulses |
| reinit_err_n | output | 1 | Bus re-init error, active low |
| bus_err_n | output | 1 | Recoverable bus error, active low |
| int_err_n | output | 1 | Internal error, active low |
| mc_req | output | 1 | Machine-check request pulse |

## Verification
The assertions assume that `por_n` is low at time zero and stays low for at least one clock edge, so that the strap latch holds a known value before any check on it is enabled. They also assume that event and configuration inputs change only between clock edges. The bench meets both conditions: it starts in power-on reset and drives every input one time unit after a rising edge. It mixes directed cases (simultaneous sources, back-to-back events, a write in the same cycle as an event, warm reset with a changed strap) with random event patterns under both strap values.

// File: rtl/err_rpt_pkg.sv
package err_rpt_pkg;
    localparam int NUM_CLS = 3;

    typedef enum logic [1:0] {
        CLS_REINIT = 2'd0,
        CLS_BUS    = 2'd1,
        CLS_INT    = 2'd2
    } err_cls_e;

    typedef logic [NUM_CLS-1:0] esc_vec_t;

    typedef struct packed {
        logic err;
        logic hit;
    } cls_state_t;
endpackage

// File: rtl/err_rpt_cfg.sv
module err_rpt_cfg
    import err_rpt_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     rst_all_n,
    input  logic     strap_drv_en,
    input  logic     cfg_we,
    input  esc_vec_t cfg_wdata,
    output logic     drv_en,
    output esc_vec_t esc_en
);
    logic     drv_d, drv_q;
    esc_vec_t esc_d, esc_q;

    always_comb begin
        drv_d = por_n ? drv_q : strap_drv_en;
        esc_d = cfg_we ? cfg_wdata : esc_q;
    end

    // strap latch: follows the strap only while power-on reset is held
    always_ff @(posedge clk) begin
        drv_q <= drv_d;
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) esc_q <= '0;
        else            esc_q <= esc_d;
    end

    assign drv_en = drv_q;
    assign esc_en = esc_q;

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!por_n)
        por_n |=> $stable(drv_en)); // R1
    AST_ESC_HOLD: assert property (@(posedge clk) disable iff (!rst_all_n)
        !cfg_we |=> $stable(esc_en)); // R7
    AST_ESC_LOAD: assert property (@(posedge clk) disable iff (!rst_all_n)
        cfg_we |=> (esc_en == $past(cfg_wdata))); // R7
endmodule

// File: rtl/err_rpt_class.sv
module err_rpt_class
    import err_rpt_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ev,
    input  logic             drv_en,
    input  logic             esc_en,
    output logic             err_n,
    output logic             mc_hit
);
    cls_state_t st_d, st_q;
    logic       fire;

    always_comb begin
        fire       = (|ev) && drv_en;
        st_d.err   = fire;
        st_d.hit   = fire && esc_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_n  = !st_q.err;
    assign mc_hit = st_q.hit;

    AST_FIRE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev) && drv_en) |=> !err_n); // R3
    AST_QUIET_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !((|ev) && drv_en) |=> err_n); // R6
    AST_HIT_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        mc_hit |-> !err_n); // R8
    AST_HIT_ESC: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev) && drv_en && esc_en) |=> mc_hit); // R8
endmodule

// File: rtl/err_reporter.sv
module err_reporter
    import err_rpt_pkg::*;
#(
    parameter int N_REINIT = 2,
    parameter int N_BUS    = 4,
    parameter int N_INT    = 3
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                rst_n,
    input  logic                strap_drv_en,
    input  logic                cfg_we,
    input  logic [NUM_CLS-1:0]  cfg_wdata,
    input  logic [N_REINIT-1:0] ev_reinit,
    input  logic [N_BUS-1:0]    ev_bus,
    input  logic [N_INT-1:0]    ev_int,
    output logic                reinit_err_n,
    output logic                bus_err_n,
    output logic                int_err_n,
    output logic                mc_req
);
    logic     rst_all_n;
    logic     drv_en;
    esc_vec_t esc_en;
    esc_vec_t hit;

    assign rst_all_n = por_n & rst_n;

    err_rpt_cfg u_cfg (
        .clk          (clk),
        .por_n        (por_n),
        .rst_all_n    (rst_all_n),
        .strap_drv_en (strap_drv_en),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .drv_en       (drv_en),
        .esc_en       (esc_en)
    );

    err_rpt_class #(.N_SRC(N_REINIT)) u_reinit (
        .clk    (clk),
        .rst_n  (rst_all_n),
        .ev     (ev_reinit),
        .drv_en (1'b1),
        .esc_en (esc_en[CLS_REINIT]),
        .err_n  (reinit_err_n),
        .mc_hit (hit[CLS_REINIT])
    );

    err_rpt_class #(.N_SRC(N_BUS)) u_bus (
        .clk    (clk),
        .rst_n  (rst_all_n),
        .ev     (ev_bus),
        .drv_en (drv_en),
        .esc_en (esc_en[CLS_BUS]),
        .err_n  (bus_err_n),
        .mc_hit (hit[CLS_BUS])
    );

    err_rpt_class #(.N_SRC(N_INT)) u_int (
        .clk    (clk),
        .rst_n  (rst_all_n),
        .ev     (ev_int),
        .drv_en (1'b1),
        .esc_en (esc_en[CLS_INT]),
        .err_n  (int_err_n),
        .mc_hit (hit[CLS_INT])
    );

    assign mc_req = |hit;

    AST_BUS_MUTED: assert property (@(posedge clk) disable iff (!por_n)
        !drv_en |-> bus_err_n); // R2
    AST_MC_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_all_n)
        mc_req |-> (!reinit_err_n || !bus_err_n || !int_err_n)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_all_n |-> (reinit_err_n && bus_err_n && int_err_n && !mc_req)); // R9
endmodule

// File: tb/tb_err_reporter.sv
module tb_err_reporter;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_drv_en = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic [1:0] ev_reinit = '0;
    logic [3:0] ev_bus = '0;
    logic [2:0] ev_int = '0;
    logic       reinit_err_n, bus_err_n, int_err_n, mc_req;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  m_strap = 1'b0;
    bit [2:0] m_esc = '0;

    always #5 clk = ~clk;

    err_reporter dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .strap_drv_en(strap_drv_en),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ev_reinit(ev_reinit),
        .ev_bus(ev_bus), .ev_int(ev_int), .reinit_err_n(reinit_err_n),
        .bus_err_n(bus_err_n), .int_err_n(int_err_n), .mc_req(mc_req)
    );

    task automatic chk(string tag, string nm, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, nm, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // one cycle: drive inputs, predict, step the clock, compare
    task automatic cyc(logic [1:0] r, logic [3:0] b, logic [2:0] i,
                       logic we, logic [2:0] wd, string tag);
        bit er, eb, ei, mc;
        ev_reinit = r; ev_bus = b; ev_int = i; cfg_we = we; cfg_wdata = wd;
        er = |r;
        eb = (|b) && m_strap;
        ei = |i;
        mc = (er && m_esc[0]) || (eb && m_esc[1]) || (ei && m_esc[2]);
        @(posedge clk); #1;
        if (we) m_esc = wd;
        ev_reinit = '0; ev_bus = '0; ev_int = '0; cfg_we = 1'b0;
        chk(tag, "reinit_err_n", reinit_err_n, !er);
        chk(tag, "bus_err_n",    bus_err_n,    !eb);
        chk(tag, "int_err_n",    int_err_n,    !ei);
        chk(tag, "mc_req",       mc_req,       mc);
    endtask

    task automatic do_reset(bit por, bit strap);
        strap_drv_en = strap;
        if (por) por_n = 1'b0; else rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reinit_err_n in reset", reinit_err_n, 1'b1);
        chk("R9", "bus_err_n in reset",    bus_err_n,    1'b1);
        chk("R9", "int_err_n in reset",    int_err_n,    1'b1);
        chk("R9", "mc_req in reset",       mc_req,       1'b0);
        por_n = 1'b1; rst_n = 1'b1;
        m_esc = '0;
        if (por) m_strap = strap;
        strap_drv_en = ~strap;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        #1;
        do_reset(1'b1, 1'b1);
        cyc(2'b00, 4'b0000, 3'b000, 1'b0, 3'b000, "R6");
        cyc(2'b00, 4'b0001, 3'b000, 1'b0, 3'b000, "R3");
        cyc(2'b00, 4'b1111, 3'b000, 1'b0, 3'b000, "R3");
        cyc(2'b00, 4'b0100, 3'b000, 1'b0, 3'b000, "R3");
        cyc(2'b00, 4'b0000, 3'b000, 1'b0, 3'b000, "R6");
        cyc(2'b00, 4'b0000, 3'b110, 1'b0, 3'b000, "R4");
        cyc(2'b11, 4'b0000, 3'b000, 1'b0, 3'b000, "R5");
        cyc(2'b01, 4'b1000, 3'b001, 1'b0, 3'b000, "R8");
        // escalation write in the same cycle as an event: old value applies
        cyc(2'b00, 4'b0010, 3'b000, 1'b1, 3'b010, "R7");
        cyc(2'b00, 4'b0010, 3'b000, 1'b0, 3'b000, "R7");
        cyc(2'b10, 4'b0000, 3'b100, 1'b0, 3'b000, "R8");
        cyc(2'b00, 4'b0000, 3'b000, 1'b1, 3'b101, "R7");
        cyc(2'b01, 4'b0000, 3'b000, 1'b0, 3'b000, "R8");
        cyc(2'b00, 4'b0000, 3'b010, 1'b0, 3'b000, "R8");
        cyc(2'b00, 4'b0001, 3'b000, 1'b0, 3'b000, "R8");
        // warm reset with the strap pin changed: escalation cleared, strap kept
        do_reset(1'b0, 1'b0);
        cyc(2'b01, 4'b0001, 3'b001, 1'b0, 3'b000, "R1");
        cyc(2'b00, 4'b0000, 3'b000, 1'b1, 3'b111, "R7");
        for (int k = 0; k < 150; k++)
            cyc(2'($urandom), 4'($urandom), 3'($urandom), 1'($urandom % 8 == 0),
                3'($urandom), "R8");
        // power-on reset with driver disabled
        do_reset(1'b1, 1'b0);
        cyc(2'b00, 4'b1111, 3'b000, 1'b0, 3'b000, "R2");
        cyc(2'b00, 4'b0000, 3'b000, 1'b1, 3'b111, "R7");
        cyc(2'b00, 4'b0101, 3'b000, 1'b0, 3'b000, "R2");
        cyc(2'b00, 4'b0001, 3'b011, 1'b0, 3'b000, "R4");
        for (int k = 0; k < 150; k++)
            cyc(2'($urandom), 4'($urandom), 3'($urandom), 1'($urandom % 8 == 0),
                3'($urandom), "R2");
        summary();
    end
endmodule